// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh and Power-Up Scheduler

This block keeps a pseudo-static RAM alive. After reset it holds the chip enable and the combined output-enable/refresh pin high for a power-up wait. It then runs a fixed number of dummy chip-enable cycles and only afterwards declares the memory ready. From then on a free-running interval counter raises a refresh request often enough that all 256 rows are visited within the retention period, less a safety margin in clock cycles.

The refresh style is a build parameter. In chip-enable-only mode the block gives one chip-enable low pulse per request, with the row taken from its own 8-bit wrapping counter on the low address lines. In auto mode chip enable stays high, and the refresh pin is pulsed low after a setup delay and then held high long enough to meet the precharge, cycle and chip-enable-delay minimums.

The block takes the memory pins from the access sequencer through a level handshake. `rf_req` rises and stays high until the refresh it asks for has completed. The sequencer answers with `rf_gnt` and keeps it high until `rf_req` falls; `rf_gnt` is only looked at while a request is pending and no refresh is running. There is no data stream, so all pins are plain control and status. A sticky overrun flag records a request that went unserved for a whole refresh interval. `acc_ok` passes an access request through only when the memory is ready and not being refreshed.

Top module: `psr_refresh_sched`

## Requirements
- R1: After reset is released, `mem_ce_n` and `mem_oe_rf_n` stay high (1), `ready`, `rf_req`, `ovr` and `acc_ok` stay low, and `mem_row` is 0, for exactly PWRUP_CYC cycles.
- R2: DUMMY_N chip-enable low pulses then follow, each low for CE_LOW_CYC cycles and high for CE_PRE_CYC cycles, with `mem_oe_rf_n`, `mem_uoe_n`, `mem_lwr_n` and `mem_uwr_n` all high. `ready` rises after the last precharge.
- R3: No request is raised before `ready`. The first `rf_req` rises exactly INTERVAL_CYC-MARGIN_CYC cycles after `ready`, and further requests come at that period. A raised request stays high until it is granted.
- R4: In chip-enable-only mode (AUTO_RF=0), the cycle after a grant of a pending request gives one `mem_ce_n` low pulse of CE_LOW_CYC cycles. During it the current row is on `mem_row` and all write strobes and output enables are high. CE_PRE_CYC precharge cycles follow. The row advances by one modulo 256 as `mem_ce_n` rises.
- R5: In auto mode (AUTO_RF=1), `mem_ce_n` stays high after `ready`. `mem_oe_rf_n` falls RFD_CYC cycles after the granted refresh starts, is low for FAP_CYC cycles, and is never low for more than FAP_MAX_CYC cycles.
- R6: In auto mode, after `mem_oe_rf_n` rises, `rf_req` stays high for max(FP_CYC, FCE_CYC-FAP_CYC, ARC_CYC-FAP_CYC) cycles and then falls.
- R7: If a request waits INTERVAL_CYC cycles without a grant, `ovr` rises exactly then. It stays high through later service until a one-cycle pulse on `ovr_clr` clears it.
- R8: `acc_ok` is low before `ready` and while a refresh is running; otherwise it follows `acc_req`.
- R9: `rf_gnt` has no effect when no request is pending: chip enable stays high and `mem_row` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rf_gnt | input | 1 | Bus grant from the access sequencer |
| ovr_clr | input | 1 | Clears the overrun flag |
| acc_req | input | 1 | Access request from the sequencer |
| ready | output | 1 | Power-up and dummy cycles complete |
| rf_req | output | 1 | Refresh needs the memory pins |
| acc_ok | output | 1 | Access may proceed |
| ovr | output | 1 | Sticky refresh overrun flag |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_rf_n | output | 1 | Lower output enable / refresh pin, active low |
| mem_uoe_n | output | 1 | Upper output enable, held high |
| mem_lwr_n | output | 1 | Lower write strobe, held high |
| mem_uwr_n | output | 1 | Upper write strobe, held high |
| mem_row | output | 8 | Row address for chip-enable-only refresh |

## Verification
The bench builds two instances side by side, one per refresh style. Both use a 20-cycle power-up wait, 8 dummy cycles, a 60-cycle interval with a 10-cycle margin, and pulse widths of 2 to 6 cycles. These values put the whole power-up sequence, many refresh periods, the row counter stepping, the exact request period and a full overrun window inside a few hundred cycles. The grant delays vary from 0 to 7 cycles, so the waiting request and the later chip-enable pulse are seen from several alignments.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_DLO,
    ST_DHI,
    ST_IDLE,
    ST_CLO,
    ST_CHI,
    ST_ASET,
    ST_ALO,
    ST_AHI
  } psr_st_e;

  function automatic int imax3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psr_interval.sv
module psr_interval #(
  parameter int PERIOD   = 3842,
  parameter int INTERVAL = 3906
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start,
  input  logic clr,
  output logic pend,
  output logic ovr
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam int WW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic [WW-1:0] wcnt;
  logic          tick;

  assign tick = run && (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wcnt <= '0;
      pend <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (run) cnt <= tick ? '0 : cnt + 1'b1;
      pend <= tick | (pend & ~start);
      if (!pend || start) wcnt <= '0;
      else if (wcnt != WW'(INTERVAL - 1)) wcnt <= wcnt + 1'b1;
      if (clr) ovr <= 1'b0;
      else if (pend && !start && wcnt == WW'(INTERVAL - 1)) ovr <= 1'b1;
    end
  end

  AST_NO_PEND_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pend); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !clr |=> ovr); // R7
  AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ovr); // R7

endmodule

// File: rtl/psr_rowctr.sv
module psr_rowctr #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [RW-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/psr_seq.sv
module psr_seq
  import psr_pkg::*;
#(
  parameter bit AUTO_RF  = 1'b0,
  parameter int PWRUP    = 50000,
  parameter int DUMMY    = 8,
  parameter int CE_LOW   = 20,
  parameter int CE_PRE   = 15,
  parameter int RFD      = 13,
  parameter int FAP      = 20,
  parameter int HOLD     = 20,
  parameter int FAP_MAX  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic gnt,
  output logic start,
  output logic step,
  output logic ready,
  output logic busy,
  output logic ce_n,
  output logic rf_n
);
  localparam int TMAX = imax3(imax3(PWRUP, CE_LOW, CE_PRE), imax3(RFD, FAP, HOLD), 1);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int DW   = $clog2(DUMMY + 1);
  localparam int LW   = $clog2(FAP_MAX + 2);

  psr_st_e       st;
  logic [TW-1:0] tmr;
  logic [DW-1:0] dcnt;
  logic [LW-1:0] lo_run;
  logic          tdone;

  assign tdone = (tmr == '0);
  assign ready = !(st inside {ST_PWR, ST_DLO, ST_DHI});
  assign busy  = st inside {ST_CLO, ST_CHI, ST_ASET, ST_ALO, ST_AHI};
  assign start = (st == ST_IDLE) && pend && gnt;
  assign step  = (st == ST_CLO) && tdone;
  assign ce_n  = !(st inside {ST_DLO, ST_CLO});
  assign rf_n  = (st != ST_ALO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_PWR;
      tmr  <= TW'(PWRUP - 1);
      dcnt <= '0;
    end else begin
      case (st)
        ST_PWR:
          if (tdone) begin st <= ST_DLO; tmr <= TW'(CE_LOW - 1); end
          else tmr <= tmr - 1'b1;
        ST_DLO:
          if (tdone) begin st <= ST_DHI; tmr <= TW'(CE_PRE - 1); end
          else tmr <= tmr - 1'b1;
        ST_DHI:
          if (!tdone) tmr <= tmr - 1'b1;
          else if (dcnt == DW'(DUMMY - 1)) st <= ST_IDLE;
          else begin
            dcnt <= dcnt + 1'b1;
            st   <= ST_DLO;
            tmr  <= TW'(CE_LOW - 1);
          end
        ST_IDLE:
          if (start) begin
            if (AUTO_RF) begin st <= ST_ASET; tmr <= TW'(RFD - 1); end
            else begin st <= ST_CLO; tmr <= TW'(CE_LOW - 1); end
          end
        ST_CLO:
          if (tdone) begin st <= ST_CHI; tmr <= TW'(CE_PRE - 1); end
          else tmr <= tmr - 1'b1;
        ST_CHI:
          if (tdone) st <= ST_IDLE;
          else tmr <= tmr - 1'b1;
        ST_ASET:
          if (tdone) begin st <= ST_ALO; tmr <= TW'(FAP - 1); end
          else tmr <= tmr - 1'b1;
        ST_ALO:
          if (tdone) begin st <= ST_AHI; tmr <= TW'(HOLD - 1); end
          else tmr <= tmr - 1'b1;
        ST_AHI:
          if (tdone) st <= ST_IDLE;
          else tmr <= tmr - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_run <= '0;
    else if (!rf_n) lo_run <= lo_run + 1'b1;
    else lo_run <= '0;
  end

  AST_INIT_RF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> rf_n); // R2
  AST_AR_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_n |-> ce_n); // R5
  AST_RF_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run <= LW'(FAP_MAX)); // R5

endmodule

// File: rtl/psr_refresh_sched.sv
module psr_refresh_sched
  import psr_pkg::*;
#(
  parameter bit AUTO_RF      = 1'b0,
  parameter int PWRUP_CYC    = 50000,
  parameter int DUMMY_N      = 8,
  parameter int INTERVAL_CYC = 3906,
  parameter int MARGIN_CYC   = 64,
  parameter int CE_LOW_CYC   = 20,
  parameter int CE_PRE_CYC   = 15,
  parameter int RFD_CYC      = 13,
  parameter int FAP_CYC      = 20,
  parameter int FP_CYC       = 8,
  parameter int FCE_CYC      = 40,
  parameter int ARC_CYC      = 35,
  parameter int FAP_MAX_CYC  = 2000,
  parameter int ROW_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_gnt,
  input  logic             ovr_clr,
  input  logic             acc_req,
  output logic             ready,
  output logic             rf_req,
  output logic             acc_ok,
  output logic             ovr,
  output logic             mem_ce_n,
  output logic             mem_oe_rf_n,
  output logic             mem_uoe_n,
  output logic             mem_lwr_n,
  output logic             mem_uwr_n,
  output logic [ROW_W-1:0] mem_row
);
  localparam int PERIOD = INTERVAL_CYC - MARGIN_CYC;
  localparam int HOLD   = imax3(FP_CYC, FCE_CYC - FAP_CYC, imax3(ARC_CYC - FAP_CYC, 1, 1));

  logic pend, start, step, busy;

  psr_interval #(.PERIOD(PERIOD), .INTERVAL(INTERVAL_CYC)) u_int (
    .clk(clk), .rst_n(rst_n), .run(ready), .start(start), .clr(ovr_clr),
    .pend(pend), .ovr(ovr)
  );

  psr_seq #(
    .AUTO_RF(AUTO_RF), .PWRUP(PWRUP_CYC), .DUMMY(DUMMY_N), .CE_LOW(CE_LOW_CYC),
    .CE_PRE(CE_PRE_CYC), .RFD(RFD_CYC), .FAP(FAP_CYC), .HOLD(HOLD), .FAP_MAX(FAP_MAX_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pend(pend), .gnt(rf_gnt), .start(start), .step(step),
    .ready(ready), .busy(busy), .ce_n(mem_ce_n), .rf_n(mem_oe_rf_n)
  );

  psr_rowctr #(.RW(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .step(step), .row(mem_row)
  );

  assign rf_req    = pend | busy;
  assign acc_ok    = acc_req & ready & ~busy;
  assign mem_uoe_n = 1'b1;
  assign mem_lwr_n = 1'b1;
  assign mem_uwr_n = 1'b1;

  AST_ACC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |-> mem_ce_n && mem_oe_rf_n && ready); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req && !rf_gnt && !busy |=> rf_req); // R3

  generate
    if (!AUTO_RF) begin : g_ce_only
      AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) && ready |-> mem_row == $past(mem_row) + 1'b1); // R4
    end else begin : g_auto
      AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_row == '0); // R5
    end
  endgenerate

endmodule

// File: tb/tb_psr_refresh_sched.sv
module tb_psr_refresh_sched;
  localparam int P_PWR = 20, P_DUM = 8, P_INT = 60, P_MAR = 10;
  localparam int P_CEL = 3, P_CEP = 2, P_RFD = 2, P_FAP = 3, P_FP = 2, P_FCE = 6, P_ARC = 5;
  localparam int PERIOD = P_INT - P_MAR;
  localparam int HOLD = 3;
  // upper byte: grant delay in cycles, lower byte: expected row
  localparam logic [15:0] VEC [0:5] = '{16'h0000, 16'h0301, 16'h0102, 16'h0703, 16'h0204, 16'h0505};

  logic clk = 1'b0, rst_n = 1'b0;
  logic gnt = 1'b0, gnt_ar = 1'b1, ovr_clr = 1'b0, acc_req = 1'b1;
  logic ready, rf_req, acc_ok, ovr, ce_n, oe_n, uoe_n, lwr_n, uwr_n;
  logic [7:0] row;
  logic ready_ar, req_ar, acc_ar, ovr_ar, ce_ar, rf_ar, uoe_ar, lwr_ar, uwr_ar;
  logic [7:0] row_ar;
  int checks = 0, errors = 0;
  bit done = 0;
  int ar_pulses = 0, ar_bad_w = 0, ar_bad_h = 0, ar_bad_l = 0, ar_ce_bad = 0;

  always #2 clk = ~clk;

  psr_refresh_sched #(.AUTO_RF(1'b0), .PWRUP_CYC(P_PWR), .DUMMY_N(P_DUM), .INTERVAL_CYC(P_INT),
    .MARGIN_CYC(P_MAR), .CE_LOW_CYC(P_CEL), .CE_PRE_CYC(P_CEP), .RFD_CYC(P_RFD), .FAP_CYC(P_FAP),
    .FP_CYC(P_FP), .FCE_CYC(P_FCE), .ARC_CYC(P_ARC), .FAP_MAX_CYC(10), .ROW_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .rf_gnt(gnt), .ovr_clr(ovr_clr), .acc_req(acc_req),
    .ready(ready), .rf_req(rf_req), .acc_ok(acc_ok), .ovr(ovr), .mem_ce_n(ce_n),
    .mem_oe_rf_n(oe_n), .mem_uoe_n(uoe_n), .mem_lwr_n(lwr_n), .mem_uwr_n(uwr_n), .mem_row(row));

  psr_refresh_sched #(.AUTO_RF(1'b1), .PWRUP_CYC(P_PWR), .DUMMY_N(P_DUM), .INTERVAL_CYC(P_INT),
    .MARGIN_CYC(P_MAR), .CE_LOW_CYC(P_CEL), .CE_PRE_CYC(P_CEP), .RFD_CYC(P_RFD), .FAP_CYC(P_FAP),
    .FP_CYC(P_FP), .FCE_CYC(P_FCE), .ARC_CYC(P_ARC), .FAP_MAX_CYC(10), .ROW_W(8)) dut_ar (
    .clk(clk), .rst_n(rst_n), .rf_gnt(gnt_ar), .ovr_clr(1'b0), .acc_req(1'b1),
    .ready(ready_ar), .rf_req(req_ar), .acc_ok(acc_ar), .ovr(ovr_ar), .mem_ce_n(ce_ar),
    .mem_oe_rf_n(rf_ar), .mem_uoe_n(uoe_ar), .mem_lwr_n(lwr_ar), .mem_uwr_n(uwr_ar), .mem_row(row_ar));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit quiet();
    return oe_n && uoe_n && lwr_n && uwr_n;
  endfunction

  // auto-refresh monitor (R5, R6)
  initial begin
    bit prev_rf = 1, prev_req = 0, track = 0, leading = 0;
    int run = 0, hold = 0, lead = 0;
    @(posedge ready_ar);
    forever begin
      @(negedge clk);
      if (!ce_ar) ar_ce_bad++;
      if (req_ar && !prev_req) begin lead = 0; leading = 1; end
      if (leading) begin
        if (!rf_ar) begin if (lead != P_RFD + 1) ar_bad_l++; leading = 0; end
        else lead++;
      end
      if (!rf_ar) run++;
      if (track) begin
        if (req_ar) hold++;
        else begin if (hold != HOLD) ar_bad_h++; track = 0; end
      end
      if (rf_ar && !prev_rf) begin
        ar_pulses++;
        if (run != P_FAP) ar_bad_w++;
        run = 0; hold = 1; track = 1;
      end
      prev_rf = rf_ar; prev_req = req_ar;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, pulses, badw, lw, pre, bad;
    logic [7:0] rseen;
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && !ready && !rf_req && !ovr && !acc_ok && row == 0, "R1 reset state", {ce_n, oe_n, ready, rf_req, ovr}, 5'b11000);
    rst_n = 1'b1;
    // power-up wait
    n = 0; bad = 0;
    do begin
      @(negedge clk); n++;
      if (ready || !oe_n || acc_ok || rf_req) bad++;
    end while (ce_n && n < 1000);
    chk(n == P_PWR, "R1 power-up length", n, P_PWR);
    chk(bad == 0, "R1 pins quiet during wait", bad, 0);
    chk(acc_ok == 0, "R8 access blocked before ready", acc_ok, 0);
    // dummy cycles
    pulses = 1; lw = 1; badw = 0; bad = 0;
    while (!ready && pulses < 100) begin
      @(negedge clk);
      if (!quiet()) bad++;
      if (!ce_n) begin
        if (lw == 0) pulses++;
        lw++;
      end else if (lw != 0) begin
        if (lw != P_CEL) badw++;
        lw = 0;
      end
    end
    chk(pulses == P_DUM, "R2 dummy pulse count", pulses, P_DUM);
    chk(badw == 0, "R2 dummy pulse width", badw, 0);
    chk(bad == 0, "R2 strobes high during dummies", bad, 0);
    chk(acc_ok == 1, "R8 access passes when ready", acc_ok, 1);
    // request period
    n = 0;
    while (!rf_req && n < 1000) begin @(negedge clk); n++; end
    chk(n == PERIOD, "R3 first request delay", n, PERIOD);
    // vector table of grant delays and expected rows
    for (int i = 0; i < 6; i++) begin
      n = 0;
      while (!rf_req && n < 1000) begin @(negedge clk); n++; end
      if (i > 0) chk(ce_n == 1, "R3 request waits without grant", ce_n, 1);
      repeat (VEC[i][15:8]) @(negedge clk);
      chk(rf_req == 1 && ce_n == 1, "R3 request held until grant", rf_req, 1);
      gnt = 1'b1;
      do @(negedge clk); while (ce_n);
      rseen = row;
      chk(acc_ok == 0, "R8 access blocked during refresh", acc_ok, 0);
      lw = 0; bad = 0;
      while (!ce_n && lw < 100) begin
        lw++;
        if (!quiet() || row != rseen) bad++;
        @(negedge clk);
      end
      chk(lw == P_CEL, "R4 refresh CE width", lw, P_CEL);
      chk(rseen == VEC[i][7:0], "R4 refresh row", rseen, VEC[i][7:0]);
      chk(bad == 0, "R4 strobes high and row stable", bad, 0);
      pre = 0;
      while (rf_req && pre < 100) begin pre++; @(negedge clk); end
      gnt = 1'b0;
      chk(pre == P_CEP, "R4 precharge length", pre, P_CEP);
      chk(row == VEC[i][7:0] + 8'd1, "R4 row advance", row, VEC[i][7:0] + 1);
    end
    // grant with nothing pending
    rseen = row; gnt = 1'b1; bad = 0;
    repeat (20) begin @(negedge clk); if (!ce_n || row != rseen) bad++; end
    gnt = 1'b0;
    chk(bad == 0, "R9 grant ignored while idle", bad, 0);
    // overrun
    while (!rf_req) @(negedge clk);
    n = 0;
    while (!ovr && n < 1000) begin @(negedge clk); n++; end
    chk(n == P_INT, "R7 overrun timing", n, P_INT);
    gnt = 1'b1;
    do @(negedge clk); while (ce_n);
    while (rf_req) @(negedge clk);
    gnt = 1'b0;
    chk(ovr == 1, "R7 overrun sticky after service", ovr, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    chk(ovr == 0, "R7 overrun cleared", ovr, 0);
    gnt = 1'b1; bad = 0;
    repeat (2 * P_INT) begin @(negedge clk); if (ovr) bad++; end
    gnt = 1'b0;
    chk(bad == 0, "R7 no overrun with prompt grants", bad, 0);
    // auto-refresh results
    chk(ar_pulses >= 3, "R5 auto refresh pulses seen", ar_pulses, 3);
    chk(ar_bad_w == 0, "R5 refresh low width", ar_bad_w, 0);
    chk(ar_bad_l == 0, "R5 refresh lead delay", ar_bad_l, 0);
    chk(ar_ce_bad == 0, "R5 CE high in auto mode", ar_ce_bad, 0);
    chk(ar_bad_h == 0, "R6 hold after refresh", ar_bad_h, 0);
    chk(row_ar == 0, "R5 row unused in auto mode", row_ar, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule